// File: doc/BRIEF.md
# Double-Rate Registered-Output RAM Wrapper

This block wraps a synchronous single-port RAM so that its registered read output costs no latency on the system clock. The RAM and its output register run from a fast clock at exactly twice the system clock rate. Every system rising edge coincides with a fast rising edge. The system side presents an address, a write strobe and write data once per slow cycle. The array is read on the fast edge that lines up with the system edge. The single output register captures that result on the next fast edge, which falls in the middle of the slow cycle. By the following system edge the registered data is stable, so the system sees the data one slow cycle after it presented the address, as it would with an unregistered RAM.

An internal phase flag tells the two kinds of fast edge apart. Edges in the middle of a slow cycle see address and control values that carry no meaning. On those edges the array neither reads nor writes and the output register holds, so the value reaching the system is never disturbed. The fast clock is the only clock the block receives. Reset is synchronous to it, and its release must be placed so that the first fast edge afterwards is a system-aligned edge.

Top module: `dbl_rate_ram`

## Requirements
- R1: While `rst` is high, every fast edge clears `rd_data` to zero and returns the phase to aligned. `rst` must fall after a mid-cycle fast edge, and the next fast edge is then treated as aligned.
- R2: Out of reset, fast edges alternate strictly between aligned and mid-cycle, and each edge is exactly one of the two.
- R3: The word at the address presented on aligned edge k appears on `rd_data` right after the following mid-cycle edge and is stable at aligned edge k+1 (one slow cycle, zero added latency).
- R4: `rd_data` changes only on mid-cycle fast edges and holds its value across aligned edges.
- R5: When `sys_we` is 1 on an aligned edge, `sys_wdata` is stored at `sys_addr` and later reads of that address return it.
- R6: Address, write strobe and write data seen on a mid-cycle edge are ignored. No write happens and the array output is not updated, so a slow cycle commits at most one write.
- R7: A read and a write to the same address on the same aligned edge return the data stored before that write.
- R8: Consecutive slow cycles may present a different address each, and each result returns in its own slow cycle without stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock, twice the system rate, rising edges aligned with the system clock |
| rst | input | 1 | Synchronous active-high reset on `clk_fast` |
| sys_addr | input | ADDR_W | Word address, sampled on aligned edges |
| sys_we | input | 1 | Write strobe, sampled on aligned edges |
| sys_wdata | input | DATA_W | Write data, sampled on aligned edges |
| rd_data | output | DATA_W | Registered read data, valid at each system edge |

## Verification
A phase flag that is out of step would move the array access onto mid-cycle edges. The mid-cycle garbage written by the bench would then land in memory or reach `rd_data`, and this would show at the very next system edge as a mismatch with the zero-latency model. An output register that loads on the wrong edge shows up as `rd_data` changing across a system edge, which the bench catches by sampling just before and just after each edge. Lost old-data ordering shows in the same slow cycle as the colliding read and write.

// File: rtl/dbl_rate_ram_pkg.sv
package dbl_rate_ram_pkg;

  typedef enum logic {
    PH_ALIGN = 1'b0,
    PH_MID   = 1'b1
  } phase_e;

  function automatic phase_e phase_next(phase_e p);
    return (p == PH_ALIGN) ? PH_MID : PH_ALIGN;
  endfunction

  function automatic int unsigned addr_width(int unsigned depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction

endpackage

// File: rtl/dr_phase_track.sv
module dr_phase_track
  import dbl_rate_ram_pkg::*;
(
  input  logic clk,
  input  logic rst,
  output logic align_edge,
  output logic capture_edge
);

  phase_e phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_ALIGN;
    else     phase_q <= phase_next(phase_q);
  end

  assign align_edge   = (phase_q == PH_ALIGN);
  assign capture_edge = (phase_q == PH_MID);

endmodule

// File: rtl/dr_ram_core.sv
module dr_ram_core #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata_q
);

  logic [DW-1:0] mem [DEPTH];

  // old data is returned when a read meets a write at the same address
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata_q <= mem[addr];
    end
  end

endmodule

// File: rtl/dr_out_reg.sv
module dr_out_reg #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/dbl_rate_ram.sv
module dbl_rate_ram
  import dbl_rate_ram_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 256,
  localparam int unsigned ADDR_W = addr_width(DEPTH)
) (
  input  logic              clk_fast,
  input  logic              rst,
  input  logic [ADDR_W-1:0] sys_addr,
  input  logic              sys_we,
  input  logic [DATA_W-1:0] sys_wdata,
  output logic [DATA_W-1:0] rd_data
);

  logic              align_edge;
  logic              capture_edge;
  logic              ram_en;
  logic              ram_we;
  logic [DATA_W-1:0] ram_q;

  dr_phase_track u_phase (
    .clk          (clk_fast),
    .rst          (rst),
    .align_edge   (align_edge),
    .capture_edge (capture_edge)
  );

  // array access only on edges shared with the system clock
  assign ram_en = align_edge;
  assign ram_we = align_edge & sys_we;

  dr_ram_core #(
    .DW    (DATA_W),
    .DEPTH (DEPTH),
    .AW    (ADDR_W)
  ) u_core (
    .clk     (clk_fast),
    .en      (ram_en),
    .we      (ram_we),
    .addr    (sys_addr),
    .wdata   (sys_wdata),
    .rdata_q (ram_q)
  );

  dr_out_reg #(
    .DW (DATA_W)
  ) u_oreg (
    .clk  (clk_fast),
    .rst  (rst),
    .load (capture_edge),
    .d    (ram_q),
    .q    (rd_data)
  );

endmodule

// File: rtl/dbl_rate_ram_chk.sv
module dbl_rate_ram_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          align_edge,
  input logic          capture_edge,
  input logic          ram_we,
  input logic [DW-1:0] ram_q,
  input logic [DW-1:0] rd_data
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (rd_data == '0) && align_edge);

  a_r2_align_then_mid: assert property (@(posedge clk) disable iff (rst)
    align_edge |=> capture_edge);

  a_r2_mid_then_align: assert property (@(posedge clk) disable iff (rst)
    capture_edge |=> align_edge);

  a_r2_one_phase: assert property (@(posedge clk) disable iff (rst)
    $countones({align_edge, capture_edge}) == 1);

  a_r3_out_takes_core: assert property (@(posedge clk) disable iff (rst)
    capture_edge |=> rd_data == $past(ram_q));

  a_r4_out_holds_align: assert property (@(posedge clk) disable iff (rst)
    align_edge |=> $stable(rd_data));

  a_r6_no_write_mid: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> align_edge);

  a_r6_core_holds_mid: assert property (@(posedge clk) disable iff (rst)
    capture_edge |=> $stable(ram_q));

endmodule

bind dbl_rate_ram dbl_rate_ram_chk #(.DW(DATA_W)) u_chk (
  .clk          (clk_fast),
  .rst          (rst),
  .align_edge   (align_edge),
  .capture_edge (capture_edge),
  .ram_we       (ram_we),
  .ram_q        (ram_q),
  .rd_data      (rd_data)
);

// File: tb/dbl_rate_ram_tb_top.sv
`timescale 1ns/1ps
module dbl_rate_ram_tb_top;

  localparam int DW    = 16;
  localparam int DEPTH = 256;
  localparam int AW    = 8;

  logic          clk_fast = 1'b0;
  logic          clk_sys  = 1'b0;
  logic          rst      = 1'b1;
  logic [AW-1:0] sys_addr  = '0;
  logic          sys_we    = 1'b0;
  logic [DW-1:0] sys_wdata = '0;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference: plain array, results due one slow cycle after capture
  logic [DW-1:0] mdl   [DEPTH];
  bit            known [DEPTH];
  logic [DW-1:0] exp_q [$];
  bit            vld_q [$];
  string         tag_q [$];
  logic [DW-1:0] pre_sample;

  dbl_rate_ram #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
    .clk_fast  (clk_fast),
    .rst       (rst),
    .sys_addr  (sys_addr),
    .sys_we    (sys_we),
    .sys_wdata (sys_wdata),
    .rd_data   (rd_data)
  );

  // 100 MHz fast clock; 50 MHz system clock divided from it
  always #5 clk_fast = ~clk_fast;
  always @(posedge clk_fast) clk_sys <= ~clk_sys;

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rd_data actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one slow cycle: check the result due now, then present new inputs
  task automatic step(logic [AW-1:0] a, logic we, logic [DW-1:0] d,
                      string tag, bit junk = 1'b0);
    @(posedge clk_sys);
    #1;
    if (exp_q.size() == 2) begin
      logic [DW-1:0] e = exp_q.pop_front();
      bit            v = vld_q.pop_front();
      string         t = tag_q.pop_front();
      if (v) begin
        check(t, rd_data, e);
        check("R4 hold across system edge", rd_data, pre_sample);
      end
    end
    if (junk) begin
      // garbage that only the mid-cycle edge sees (R6)
      sys_addr  = a ^ 8'hA5;
      sys_we    = 1'b1;
      sys_wdata = 16'hDEAD;
    end else begin
      sys_addr  = a;
      sys_we    = we;
      sys_wdata = d;
    end
    exp_q.push_back(mdl[a]);
    vld_q.push_back(known[a]);
    tag_q.push_back(tag);
    if (we) begin
      mdl[a]   = d;
      known[a] = 1'b1;
    end
    @(negedge clk_sys);
    #1;
    if (junk) begin
      sys_addr  = a;
      sys_we    = we;
      sys_wdata = d;
    end
    #6;
    pre_sample = rd_data;
  endtask

  function automatic logic [DW-1:0] pat(int i);
    return DW'((i * 16'h0101) ^ 16'h5A3C);
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;
    // R1: output cleared during reset
    repeat (3) begin
      @(posedge clk_sys);
      #1;
      check("R1 reset clears output", rd_data, '0);
    end
    // release after a mid-cycle edge so the next fast edge is aligned
    @(posedge clk_sys);
    #11;
    rst = 1'b0;
    #6;
    pre_sample = rd_data;
    check("R1 output zero after release", rd_data, '0);

    // R5: fill every word
    for (int i = 0; i < DEPTH; i++) step(AW'(i), 1'b1, pat(i), "R5 write");
    // R3 / R8: back-to-back reads, one new address per slow cycle
    for (int i = 0; i < DEPTH; i++) step(AW'(i), 1'b0, '0, "R3 R8 read back");
    for (int i = DEPTH - 1; i >= 0; i -= 7) step(AW'(i), 1'b0, '0, "R8 descending reads");
    // R7: collide read and write
    for (int i = 0; i < 8; i++) step(AW'(i * 9), 1'b1, 16'h1000 + 16'(i), "R7 old data on collision");
    for (int i = 0; i < 8; i++) step(AW'(i * 9), 1'b0, '0, "R5 new data after write");
    // R6: mid-cycle garbage must not write or reach the output
    for (int i = 0; i < 12; i++) step(AW'(40 + i), 1'b0, '0, "R6 mid-cycle inputs ignored", 1'b1);
    for (int i = 0; i < 12; i++) step(AW'(40 + i) ^ 8'hA5, 1'b0, '0, "R6 no stray write");
    // R5: write then read the next cycle
    for (int i = 0; i < 6; i++) begin
      step(AW'(200 + i), 1'b1, 16'hC000 | 16'(i), "R5 write");
      step(AW'(200 + i), 1'b0, '0, "R5 read next cycle");
    end
    step('0, 1'b0, '0, "drain");
    step('0, 1'b0, '0, "drain");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule